// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front End

This block is the host-facing register front end of a floppy disk controller. After reset it works in a legacy soft-switch mode. In this mode the address of each access, read or write, flips one of eight single-bit switches. The switches are four stepper phase lines, motor enable, drive select, and two qualifier switches called Q6 and Q7. When both qualifiers are set, a written byte lands in a legacy data register if the motor switch is set, and in a legacy mode register if it is not.

Software leaves the legacy mode by writing four bytes to the legacy mode register: 0x57, 0x17, 0x57, 0x57. An escape detector follows this sequence. When it completes, the block moves for good into an extended mode with a conventional indexed register map. That map holds a phase register, a mode register with separate bit-set and bit-clear write ports, and a handshake read that reports drive sense.

The switch bank, the legacy registers and the extended registers are all brought out as control outputs for the drive logic further downstream. Drive mechanics, encoding, FIFOs and CRC handling sit outside this block.

The front end is built around two state machines:
- The controller mode machine has two states. MODE_LEGACY moves to MODE_EXTENDED on the transition *escape hit*. MODE_EXTENDED has no exit except reset.
- The escape detector has four states. DET_WAIT_A advances to DET_WAIT_B on a mode-register write of 0x57. DET_WAIT_B advances to DET_WAIT_C on 0x17. DET_WAIT_C advances to DET_WAIT_D on 0x57. DET_WAIT_D returns to DET_WAIT_A on 0x57, and that transition raises *escape hit*. Any other byte leaves the state where it is.

Top module: `fdc_regif`

## Requirements
- R1: The 4-bit register index is taken from address bits [12:9] of the 8 KB window. Address bits [8:0] have no effect.
- R2: In legacy mode, every read or write sets switch `sw_legacy[idx>>1]` to `idx[0]`. Switch bits are: [3:0] phase lines, [4] motor, [5] drive select, [6] Q6, [7] Q7. For example, index 9 sets motor and index 8 clears it.
- R3: A legacy write stores its byte only when Q6 and Q7 are both 1. The switch update from that same access is applied before this test. When the byte is stored, it goes to `legacy_data` if motor is 1 and to `legacy_mode` otherwise.
- R4: Legacy mode-register bytes 0x57, 0x17, 0x57, 0x57, written in that order, raise `ext_active`. The detector then returns to its first state.
- R5: A mode-register byte that does not match the byte the detector expects leaves the detector state unchanged. Writes that are not stored (gated off, or sent to the data register) do not advance the detector.
- R6: Reads in legacy mode return 0x00.
- R7: In extended mode, a write to index 4 loads `ext_phase`. A write to index 6 clears the `ext_mode` bits that are 1 in the data. A write to index 7 sets the `ext_mode` bits that are 1 in the data. Writes to indices 0–3 and 5 change nothing. Repeated set or clear writes give the same result.
- R8: In extended mode, a read of index 12 returns `ext_phase`. A read of index 15 returns 0x08 when `ext_phase` is 0x77, and 0x00 otherwise. All other indices read 0x00.
- R9: Extended mode is permanent until reset. While in it, accesses do not change the switches, `legacy_data` or `legacy_mode`.
- R10: Reset selects legacy mode and clears the detector, the switches, the legacy registers, the extended registers and `rdata`.
- R11: The register and switch outputs show the effect of an access after the clock edge that samples the strobe. `rdata` holds the read result from that same edge until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (13) | Byte address within the window |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| ext_active | output | 1 | 1 once extended mode is entered |
| sw_legacy | output | 8 | Legacy soft-switch bank |
| legacy_data | output | 8 | Legacy data register |
| legacy_mode | output | 8 | Legacy mode register |
| ext_phase | output | 8 | Extended phase register |
| ext_mode | output | 8 | Extended mode register |

## Verification
Every result of this block is due exactly one clock edge after its strobe. This covers switch flips, legacy register loads, the `ext_active` rise on the fourth escape byte, extended register updates and `rdata`. The driver raises a strobe on a falling edge and drops it on the next falling edge. Port checks are taken right after that falling edge, half a cycle after the updating edge. For reads, a monitor notes which rising edge captured `rd_en` and compares `rdata` with the queued expected byte on the following falling edge.

// File: rtl/fdc_regif_pkg.sv
package fdc_regif_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;

    // switch bit positions inside the soft-switch bank
    localparam int SW_MOTOR = 4;
    localparam int SW_Q6    = 6;
    localparam int SW_Q7    = 7;

    // extended register indices
    localparam logic [IDX_W-1:0] IDX_PHASE_WR = 4'd4;
    localparam logic [IDX_W-1:0] IDX_MODE_CLR = 4'd6;
    localparam logic [IDX_W-1:0] IDX_MODE_SET = 4'd7;
    localparam logic [IDX_W-1:0] IDX_PHASE_RD = 4'd12;
    localparam logic [IDX_W-1:0] IDX_HANDSHK  = 4'd15;

    // escape key bytes and handshake encoding
    localparam logic [DATA_W-1:0] KEY_OUTER   = 8'h57;
    localparam logic [DATA_W-1:0] KEY_INNER   = 8'h17;
    localparam logic [DATA_W-1:0] SENSE_PHASE = 8'h77;
    localparam logic [DATA_W-1:0] SENSE_FLAG  = 8'h08;

    typedef enum logic [1:0] {
        DET_WAIT_A,
        DET_WAIT_B,
        DET_WAIT_C,
        DET_WAIT_D
    } det_state_t;

    typedef enum logic {
        MODE_LEGACY,
        MODE_EXTENDED
    } ctl_mode_t;

endpackage

// File: rtl/fdc_legacy_switches.sv
module fdc_legacy_switches
    import fdc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        sw_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] mode_q,
    output logic              mode_wr
);

    logic [7:0] sw_next;
    logic       store_ok;
    logic       data_wr;

    // switch update first, then the qualifier test on the new value
    always_comb begin
        sw_next = sw_q;
        sw_next[idx[IDX_W-1:1]] = idx[0];
        store_ok = acc_en && acc_wr && sw_next[SW_Q6] && sw_next[SW_Q7];
        data_wr  = store_ok && sw_next[SW_MOTOR];
        mode_wr  = store_ok && !sw_next[SW_MOTOR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q   <= '0;
            data_q <= '0;
            mode_q <= '0;
        end else begin
            if (acc_en)  sw_q   <= sw_next;
            if (data_wr) data_q <= wdata;
            if (mode_wr) mode_q <= wdata;
        end
    end

    // R9: without an enabled access the bank is frozen
    assert_sw_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(sw_q));

    // R3: a qualified write never leaves both qualifiers clear
    assert_gate_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (sw_q[SW_Q6] && sw_q[SW_Q7] && !sw_q[SW_MOTOR]));

endmodule

// File: rtl/fdc_escape_detector.sv
module fdc_escape_detector
    import fdc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [DATA_W-1:0] key_byte,
    output logic              hit
);

    det_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                DET_WAIT_A: if (key_byte == KEY_OUTER) state_d = DET_WAIT_B;
                DET_WAIT_B: if (key_byte == KEY_INNER) state_d = DET_WAIT_C;
                DET_WAIT_C: if (key_byte == KEY_OUTER) state_d = DET_WAIT_D;
                DET_WAIT_D: if (key_byte == KEY_OUTER) state_d = DET_WAIT_A;
            endcase
        end
    end

    always_comb begin
        hit = step && (state_q == DET_WAIT_D) && (key_byte == KEY_OUTER);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DET_WAIT_A;
        else        state_q <= state_d;
    end

    // R4: a completed escape puts the detector back at its first state
    assert_hit_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == DET_WAIT_A));

    // R5: bytes that are neither key value never move the detector
    assert_mismatch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && key_byte != KEY_OUTER && key_byte != KEY_INNER) |=> $stable(state_q));

    // R5: no stored mode byte, no movement
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/fdc_ext_regs.sv
module fdc_ext_regs
    import fdc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] phase_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= '0;
        end else if (acc_en && acc_wr) begin
            unique case (idx)
                IDX_PHASE_WR: phase_q <= wdata;
                IDX_MODE_CLR: mode_q  <= mode_q & ~wdata;
                IDX_MODE_SET: mode_q  <= mode_q | wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_PHASE_RD: rd_val = phase_q;
            IDX_HANDSHK:  rd_val = (phase_q == SENSE_PHASE) ? SENSE_FLAG : '0;
            default:      rd_val = '0;
        endcase
    end

    // R7: set port leaves every written one set
    assert_mode_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && idx == IDX_MODE_SET) |=> ((mode_q & $past(wdata)) == $past(wdata)));

    // R7: clear port leaves every written one clear
    assert_mode_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && idx == IDX_MODE_CLR) |=> ((mode_q & $past(wdata)) == '0));

    // R7: unused write indices touch nothing
    assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && (idx inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}))
            |=> ($stable(phase_q) && $stable(mode_q)));

endmodule

// File: rtl/fdc_regif.sv
module fdc_regif
    import fdc_regif_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              ext_active,
    output logic [7:0]        sw_legacy,
    output logic [7:0]        legacy_data,
    output logic [7:0]        legacy_mode,
    output logic [7:0]        ext_phase,
    output logic [7:0]        ext_mode
);

    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    ctl_mode_t         mode_q, mode_d;
    logic [IDX_W-1:0]  idx;
    logic              acc;
    logic              leg_en;
    logic              ext_en;
    logic              mode_wr;
    logic              esc_hit;
    logic [DATA_W-1:0] ext_rd;
    logic              unused_addr;

    assign idx         = addr[IDX_MSB:IDX_LSB];
    assign unused_addr = ^addr;
    assign acc         = wr_en || rd_en;
    assign leg_en      = acc && (mode_q == MODE_LEGACY);
    assign ext_en      = acc && (mode_q == MODE_EXTENDED);

    fdc_legacy_switches u_switches (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (leg_en),
        .acc_wr  (wr_en),
        .idx     (idx),
        .wdata   (wdata),
        .sw_q    (sw_legacy),
        .data_q  (legacy_data),
        .mode_q  (legacy_mode),
        .mode_wr (mode_wr)
    );

    fdc_escape_detector u_escape (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (mode_wr),
        .key_byte (wdata),
        .hit      (esc_hit)
    );

    fdc_ext_regs u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (ext_en),
        .acc_wr  (wr_en),
        .idx     (idx),
        .wdata   (wdata),
        .phase_q (ext_phase),
        .mode_q  (ext_mode),
        .rd_val  (ext_rd)
    );

    // controller mode: next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LEGACY:   if (esc_hit) mode_d = MODE_EXTENDED;
            MODE_EXTENDED: mode_d = MODE_EXTENDED;
        endcase
    end

    // controller mode: state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_LEGACY;
        else        mode_q <= mode_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= (mode_q == MODE_EXTENDED) ? ext_rd : '0;
    end

    assign ext_active = (mode_q == MODE_EXTENDED);

    // R9: extended mode never falls back
    assert_ext_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active |=> ext_active);

    // R9: legacy registers frozen once extended
    assert_legacy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active |=> ($stable(legacy_data) && $stable(legacy_mode)));

    // R6: legacy reads are zero
    assert_legacy_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ext_active) |=> (rdata == '0));

    // R8: handshake reports sense on the matching phase
    assert_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ext_active && idx == IDX_HANDSHK && ext_phase == SENSE_PHASE)
            |=> (rdata == SENSE_FLAG));

endmodule

// File: tb/fdc_regif_bench.sv
`timescale 1ns/1ps
module fdc_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        ext_active;
    logic [7:0]  sw_legacy, legacy_data, legacy_mode, ext_phase, ext_mode;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    logic [7:0] exp_sw = '0;
    logic       exp_ext = 1'b0;

    always #2 clk = ~clk;

    fdc_regif u_fdc_regif (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .ext_active(ext_active), .sw_legacy(sw_legacy),
        .legacy_data(legacy_data), .legacy_mode(legacy_mode),
        .ext_phase(ext_phase), .ext_mode(ext_mode)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compare read data half a cycle after the capturing edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R11: unexpected read result %02h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // one access; entered and left on a falling edge
    task automatic access(input logic w, input logic [3:0] idx, input logic [7:0] d);
        addr  = {idx, 9'h1A5};
        wdata = d;
        wr_en = w;
        rd_en = !w;
        if (!exp_ext) exp_sw[idx[3:1]] = idx[0];
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        access(1'b1, idx, d);
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, idx, 8'h00);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 sw", sw_legacy, 8'h00);
        check("R10 ext", {7'b0, ext_active}, 8'h00);
        check("R10 data", legacy_data, 8'h00);
        check("R10 rdata", rdata, 8'h00);

        // R2/R6/R1: motor on via a read, address low bits ignored
        rd(4'd9, 8'h00, "R6 legacy read");
        check("R2 motor on", sw_legacy, 8'h10);
        wr(4'd1, 8'hC3);
        check("R2 phase0", sw_legacy, exp_sw);
        check("R3 gated data", legacy_data, 8'h00);
        check("R3 gated mode", legacy_mode, 8'h00);
        wr(4'd0, 8'h00);
        check("R1 index decode", sw_legacy, 8'h10);

        // R5: full key with Q6 clear does not advance
        rd(4'd15, 8'h00, "R6 legacy read q7");
        wr(4'd8, 8'h57); wr(4'd8, 8'h17); wr(4'd8, 8'h57); wr(4'd8, 8'h57);
        check("R5 no store q6 clear", legacy_mode, 8'h00);
        check("R5 no escape q6 clear", {7'b0, ext_active}, 8'h00);

        // R3: qualifiers set, motor on -> data register
        rd(4'd13, 8'h00, "R6 legacy read q6");
        wr(4'd9, 8'hA5);
        check("R3 data store", legacy_data, 8'hA5);
        check("R3 mode untouched", legacy_mode, 8'h00);
        // R3: switch applied before gate (Q7 cleared by this write)
        wr(4'd14, 8'h33);
        check("R3 q7 cleared first", legacy_mode, 8'h00);
        check("R3 q7 cleared data", legacy_data, 8'hA5);
        rd(4'd15, 8'h00, "R6 legacy read q7 again");

        // R4/R5: interrupted sequence still completes
        wr(4'd8, 8'h57);
        check("R3 mode store", legacy_mode, 8'h57);
        wr(4'd8, 8'h17);
        wr(4'd8, 8'h57);
        check("R4 not yet", {7'b0, ext_active}, 8'h00);
        wr(4'd8, 8'h00);
        wr(4'd8, 8'h17);
        check("R5 held", {7'b0, ext_active}, 8'h00);
        wr(4'd8, 8'h57);
        exp_ext = 1'b1;
        check("R4 escape", {7'b0, ext_active}, 8'h01);
        check("R2 switch model", sw_legacy, exp_sw);

        // R7/R8 extended map, R9 soft switches ignored
        wr(4'd4, 8'h77);
        check("R7 phase", ext_phase, 8'h77);
        check("R9 sw frozen", sw_legacy, exp_sw);
        rd(4'd12, 8'h77, "R8 phase read");
        rd(4'd15, 8'h08, "R8 handshake sense");
        rd(4'd13, 8'h00, "R8 other read");
        wr(4'd4, 8'h76);
        rd(4'd15, 8'h00, "R8 handshake clear");
        wr(4'd7, 8'h91); wr(4'd7, 8'h91);
        check("R7 set idempotent", ext_mode, 8'h91);
        wr(4'd6, 8'h11); wr(4'd6, 8'h11);
        check("R7 clear idempotent", ext_mode, 8'h80);
        for (int i = 0; i < 6; i++) if (i != 4) wr(4'(i), 8'hFF);
        check("R7 ignored phase", ext_phase, 8'h76);
        check("R7 ignored mode", ext_mode, 8'h80);
        wr(4'd9, 8'h3C);
        wr(4'd8, 8'h57);
        check("R9 sw ignored", sw_legacy, exp_sw);
        check("R9 data frozen", legacy_data, 8'hA5);
        check("R9 mode frozen", legacy_mode, 8'h57);
        check("R9 still ext", {7'b0, ext_active}, 8'h01);

        // R10 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_sw = '0; exp_ext = 1'b0;
        check("R10 ext cleared", {7'b0, ext_active}, 8'h00);
        check("R10 phase cleared", ext_phase, 8'h00);
        check("R10 mode cleared", ext_mode, 8'h00);
        check("R10 legacy cleared", legacy_data | legacy_mode | sw_legacy, 8'h00);
        wr(4'd4, 8'h55);
        check("R10 back to legacy", ext_phase, 8'h00);
        rd(4'd12, 8'h00, "R6 legacy after reset");

        repeat (2) @(negedge clk);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: actual %0d pending reads expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule